// File: doc/BRIEF.md
# Block-Framed Clocked Serial Slave

This block is the slave end of a clocked serial link. The master drives the serial clock. On every exchange the slave shifts one byte in and one byte out at the same time. Bytes are grouped into blocks of a fixed length, eight by default. The local side loads an eight-entry transmit buffer. Each byte received from the master is presented with a single-cycle strobe, together with its position inside the current block.

There is no select line, so the slave finds the start of a block by watching for silence. A periodic tick input drives a down-counter. Each completed byte reloads that counter. If enough ticks pass with no byte completing, the slave realigns. It drops any partial byte, sets its position count back to zero, and puts buffer entry 0 on the output. Once the master has gone past the end of the block, every further byte it clocks out gets the all-ones filler.

The serial clock and data input are brought into the system clock domain through a flop chain before edges are detected. Bytes travel most significant bit first.

Top module: `blk_serial_slave`

## Requirements
- R1: The slave samples the data input on each rising serial clock edge, most significant bit first. After the eighth rising edge the assembled byte appears on `rx_data_o`, with `rx_valid_o` high for exactly one system clock cycle.
- R2: `sdo_o` changes only on a falling serial clock edge inside a byte, or when a new transmit byte is loaded. The output shifts most significant bit first. Bit 7 of a newly loaded byte is on the line before the first rising edge of that byte.
- R3: `rx_index_o` gives the received byte's position in the block, from 0 to 7, with `rx_overflow_o` low. The ninth and any later byte of a block are flagged with `rx_overflow_o` high, and `rx_index_o` then holds 7.
- R4: When a byte completes at position p, the slave loads transmit buffer entry p+1 if p+1 is below 8. Otherwise it loads the filler 0xFF.
- R5: The silence counter is reloaded with `TMO_RELOAD` whenever a byte completes. It decreases by one on each `tick_i` pulse. Fewer than `TMO_RELOAD` ticks after a byte cause no realignment.
- R6: When the silence counter steps from 1 to 0, the slave discards any partially received bits and sets the position count back to 0. It also loads buffer entry 0 for transmission.
- R7: After it expires, the silence counter stays at zero under further ticks and does not realign again until a byte completes.
- R8: After reset and after a realignment, the slave is in an idle state until the first rising edge. While idle, `sdo_o` follows bit 7 of buffer entry 0, including writes made to it during that time. The next byte received has index 0.
- R9: A write with `tx_we_i` high stores `tx_wdata_i` at entry `tx_waddr_i` (0 to 7). That entry is what the slave sends when it reaches that position in the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| sdi_i | input | 1 | Serial data from the master (asynchronous) |
| sdo_o | output | 1 | Serial data to the master |
| tick_i | input | 1 | One-cycle periodic tick for silence timing |
| tx_we_i | input | 1 | Transmit buffer write enable |
| tx_waddr_i | input | 3 | Transmit buffer entry index |
| tx_wdata_i | input | 8 | Transmit buffer write data |
| rx_valid_o | output | 1 | One-cycle strobe for a completed received byte |
| rx_data_o | output | 8 | Received byte |
| rx_index_o | output | 3 | Position of the received byte within its block |
| rx_overflow_o | output | 1 | Received byte lies beyond the block length |

## Verification
The received byte values include all-zeros, all-ones and several arithmetic patterns. These show whether the received bits are ordered correctly and whether a stuck bit is present. Every bit the slave transmits is checked against the buffer entry or the filler. A long run of ten bytes in one block checks the index sequence and the point where the filler and the overflow flag begin. Tick counts one short of the reload value and exactly equal to it show whether the silence counter realigns at the right moment. A half-received byte followed by a timeout shows whether the stale bits are thrown away. Writes made while the slave is idle show whether `sdo_o` tracks entry 0 live.

// File: rtl/ss_pkg.sv
package ss_pkg;
    // Source selected for the next transmit shift register value
    typedef enum logic [2:0] {
        TXL_HOLD,
        TXL_SHIFT,
        TXL_NEXT,
        TXL_FIRST,
        TXL_FILL
    } tx_load_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic sdi_o
);
    typedef struct packed {
        logic [STAGES-1:0] sck_sr;
        logic [STAGES-1:0] sdi_sr;
        logic              sck_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.sck_sr   = {s_q.sck_sr[STAGES-2:0], sck_i};
        s_d.sdi_sr   = {s_q.sdi_sr[STAGES-2:0], sdi_i};
        s_d.sck_prev = s_q.sck_sr[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck_rise_o = s_q.sck_sr[STAGES-1] & ~s_q.sck_prev;
    assign sck_fall_o = ~s_q.sck_sr[STAGES-1] & s_q.sck_prev;
    assign sdi_o      = s_q.sdi_sr[STAGES-1];
endmodule

// File: rtl/ss_txbuf.sv
module ss_txbuf #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] ent_flat [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [WIDTH-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we_i && (waddr_i == AW'(i))) ent_d = wdata_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ent_flat[i] = ent_q;
    end

    assign rdata_o = ent_flat[raddr_i];
endmodule

// File: rtl/ss_timeout.sv
module ss_timeout #(
    parameter int CNT_W  = 8,
    parameter int RELOAD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic             tick_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (reload_i) begin
            cnt_d = CNT_W'(RELOAD);
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d    = cnt_q - CNT_W'(1);
            expire_o = (cnt_q == CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/blk_serial_slave.sv
module blk_serial_slave #(
    parameter int BLOCK_LEN   = 8,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 8,
    parameter int TMO_RELOAD  = 8,
    localparam int IDX_W      = $clog2(BLOCK_LEN),
    localparam int CNT_W      = IDX_W + 1,
    localparam int BIT_W      = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic              tick_i,
    input  logic              tx_we_i,
    input  logic [IDX_W-1:0]  tx_waddr_i,
    input  logic [BYTE_W-1:0] tx_wdata_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic [IDX_W-1:0]  rx_index_o,
    output logic              rx_overflow_o
);
    import ss_pkg::*;

    typedef struct packed {
        logic              idle;
        logic [BIT_W-1:0]  bit_cnt;
        logic [CNT_W-1:0]  byte_cnt;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] tx_sh;
        logic [BYTE_W-1:0] rx_data;
        logic              rx_valid;
        logic [IDX_W-1:0]  rx_index;
        logic              rx_ovf;
    } core_t;

    core_t st_d, st_q;

    logic              sck_rise, sck_fall, sdi_s;
    logic              byte_done, tmo_expire, blk_full, next_in_blk, idle_w;
    logic [CNT_W-1:0]  next_pos;
    logic [IDX_W-1:0]  rd_addr;
    logic [BYTE_W-1:0] rd_data, rx_next;
    logic [TMO_W-1:0]  tmo_cnt;
    tx_load_e          tx_sel;

    ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .sdi_i      (sdi_i),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .sdi_o      (sdi_s)
    );

    ss_txbuf #(.DEPTH(BLOCK_LEN), .WIDTH(BYTE_W)) u_txbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (tx_we_i),
        .waddr_i (tx_waddr_i),
        .wdata_i (tx_wdata_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    ss_timeout #(.CNT_W(TMO_W), .RELOAD(TMO_RELOAD)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (byte_done),
        .tick_i   (tick_i),
        .expire_o (tmo_expire),
        .cnt_o    (tmo_cnt)
    );

    // Position bookkeeping derived from registered state
    assign byte_done   = sck_rise && (st_q.bit_cnt == BIT_W'(BYTE_W - 1));
    assign blk_full    = st_q.byte_cnt >= CNT_W'(BLOCK_LEN);
    assign next_pos    = st_q.byte_cnt + CNT_W'(1);
    assign next_in_blk = next_pos < CNT_W'(BLOCK_LEN);
    assign rx_next     = {st_q.rx_sh[BYTE_W-2:0], sdi_s};
    assign idle_w      = st_q.idle;

    // Buffer read address: entry 0 when idle or realigning, else next slot
    always_comb begin
        if (st_q.idle || (tmo_expire && !byte_done)) rd_addr = '0;
        else if (next_in_blk)                      rd_addr = next_pos[IDX_W-1:0];
        else                                       rd_addr = '0;
    end

    // Select what the transmit shift register takes next
    always_comb begin
        tx_sel = TXL_HOLD;
        if (byte_done)                          tx_sel = next_in_blk ? TXL_NEXT : TXL_FILL;
        else if (tmo_expire)                    tx_sel = TXL_FIRST;
        else if (st_q.idle)                     tx_sel = TXL_FIRST;
        else if (sck_fall && st_q.bit_cnt != '0) tx_sel = TXL_SHIFT;
    end

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = 1'b0;

        if (byte_done) begin
            st_d.rx_sh    = rx_next;
            st_d.rx_data  = rx_next;
            st_d.rx_valid = 1'b1;
            st_d.rx_ovf   = blk_full;
            st_d.rx_index = blk_full ? IDX_W'(BLOCK_LEN - 1) : st_q.byte_cnt[IDX_W-1:0];
            st_d.byte_cnt = blk_full ? st_q.byte_cnt : next_pos;
            st_d.bit_cnt  = '0;
            st_d.idle     = 1'b0;
        end else if (tmo_expire) begin
            st_d.byte_cnt = '0;
            st_d.bit_cnt  = '0;
            st_d.rx_sh    = '0;
            st_d.idle     = 1'b1;
        end else if (sck_rise) begin
            st_d.rx_sh   = rx_next;
            st_d.bit_cnt = st_q.bit_cnt + BIT_W'(1);
            st_d.idle    = 1'b0;
        end

        unique case (tx_sel)
            TXL_SHIFT: st_d.tx_sh = {st_q.tx_sh[BYTE_W-2:0], 1'b1};
            TXL_NEXT:  st_d.tx_sh = rd_data;
            TXL_FIRST: st_d.tx_sh = rd_data;
            TXL_FILL:  st_d.tx_sh = '1;
            default:   st_d.tx_sh = st_q.tx_sh;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o         = st_q.tx_sh[BYTE_W-1];
    assign rx_valid_o    = st_q.rx_valid;
    assign rx_data_o     = st_q.rx_data;
    assign rx_index_o    = st_q.rx_index;
    assign rx_overflow_o = st_q.rx_ovf;
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
    parameter int TMO_W      = 8,
    parameter int TMO_RELOAD = 8,
    parameter int IDX_W      = 3,
    parameter int BLOCK_LEN  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             byte_done,
    input logic             expire,
    input logic             idle,
    input logic             tick,
    input logic [TMO_W-1:0] tmo_cnt,
    input logic             rx_valid,
    input logic [IDX_W-1:0] rx_index,
    input logic             rx_ovf
);
    // R1: strobe is one cycle and follows a detected rising edge
    assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_valid_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sck_rise));

    // R2: output moves only after a fall, a load, or while idle tracking
    assert_sdo_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(sck_fall || byte_done || expire || idle));

    // R3: overflow bytes report the last index
    assert_ovf_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ovf) |-> (rx_index == IDX_W'(BLOCK_LEN - 1)));

    // R5: reload on byte completion, decrement on tick
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (tmo_cnt == TMO_W'(TMO_RELOAD)));
    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !byte_done && tmo_cnt != '0) |=> (tmo_cnt == $past(tmo_cnt) - TMO_W'(1)));

    // R6: realignment leaves the slave idle
    assert_expire_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !byte_done) |=> idle);

    // R7: counter at zero neither expires nor moves without a byte
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_cnt == '0 && !byte_done) |-> !expire);
    assert_stay_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_cnt == '0 && !byte_done) |=> (tmo_cnt == '0));
endmodule

bind blk_serial_slave ss_checker #(
    .TMO_W      (TMO_W),
    .TMO_RELOAD (TMO_RELOAD),
    .IDX_W      (IDX_W),
    .BLOCK_LEN  (BLOCK_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo       (sdo_o),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .byte_done (byte_done),
    .expire    (tmo_expire),
    .idle      (idle_w),
    .tick      (tick_i),
    .tmo_cnt   (tmo_cnt),
    .rx_valid  (rx_valid_o),
    .rx_index  (rx_index_o),
    .rx_ovf    (rx_overflow_o)
);

// File: tb/blk_serial_slave_tb.sv
module blk_serial_slave_tb;
    localparam int RL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sdi = 1'b0, tick = 1'b0, we = 1'b0;
    logic [2:0] waddr = '0;
    logic [7:0] wdata = '0;
    logic       sdo, rx_valid, rx_ovf;
    logic [7:0] rx_data;
    logic [2:0] rx_index;

    always #4 clk = ~clk;

    blk_serial_slave #(.TMO_RELOAD(RL)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_i         (sck),
        .sdi_i         (sdi),
        .sdo_o         (sdo),
        .tick_i        (tick),
        .tx_we_i       (we),
        .tx_waddr_i    (waddr),
        .tx_wdata_i    (wdata),
        .rx_valid_o    (rx_valid),
        .rx_data_o     (rx_data),
        .rx_index_o    (rx_index),
        .rx_overflow_o (rx_ovf)
    );

    int n_vec = 0, n_bad = 0, n_cap = 0;
    logic [7:0] cap_data;
    logic [2:0] cap_idx;
    logic       cap_ovf;
    logic [7:0] txb [8];

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            cap_data = rx_data;
            cap_idx  = rx_index;
            cap_ovf  = rx_ovf;
            n_cap    = n_cap + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; waddr = 3'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
        txb[a] = d;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // Clock nbits bits of m; optionally check each transmitted bit
    task automatic send_bits(input logic [7:0] m, input int nbits,
                             input logic [7:0] exp_tx, input bit do_chk);
        for (int b = 7; b > 7 - nbits; b--) begin
            @(negedge clk);
            sck = 1'b0; sdi = m[b];
            repeat (8) @(negedge clk);
            if (do_chk) chk("R2 R4 sdo bit", 32'(sdo), 32'(exp_tx[b]));
            sck = 1'b1;
            repeat (8) @(negedge clk);
        end
        sck = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] m, input logic [7:0] exp_tx,
                             input int exp_idx, input bit exp_ovf);
        int base;
        base = n_cap;
        send_bits(m, 8, exp_tx, 1'b1);
        chk("R1 one strobe per byte", 32'(n_cap - base), 32'd1);
        chk("R1 received data", 32'(cap_data), 32'(m));
        chk("R3 index", 32'(cap_idx), 32'(exp_idx));
        chk("R3 overflow flag", 32'(cap_ovf), 32'(exp_ovf));
    endtask

    function automatic logic [7:0] pat(input int k);
        if (k == 0) return 8'h00;
        if (k == 1) return 8'hFF;
        return 8'(k * 37 + 11);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) txb[i] = '0;
        repeat (5) @(negedge clk);
        // R8: reset state
        chk("R8 reset sdo", 32'(sdo), 32'd0);
        chk("R8 reset valid", 32'(rx_valid), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 no strobe after reset", 32'(n_cap), 32'd0);

        // R9: load buffer; R8 idle tracking of entry 0
        for (int i = 0; i < 8; i++) wr(i, 8'(8'h96 + i * 8'h1D));
        repeat (4) @(negedge clk);
        chk("R8 idle tracks entry0 msb", 32'(sdo), 32'(txb[0][7]));
        wr(0, 8'h16);
        repeat (4) @(negedge clk);
        chk("R8 idle tracks rewrite", 32'(sdo), 32'd0);
        wr(0, 8'h96);
        repeat (4) @(negedge clk);
        chk("R8 idle tracks rewrite back", 32'(sdo), 32'd1);

        // R1 R3 R4: ten bytes, the last two past the block
        for (int k = 0; k < 10; k++)
            send_byte(pat(k), (k < 8) ? txb[k] : 8'hFF, (k < 8) ? k : 7, k >= 8);

        // R6: silence realigns
        ticks(RL);
        chk("R6 entry0 after realign", 32'(sdo), 32'(txb[0][7]));
        for (int k = 0; k < 3; k++) send_byte(pat(k + 20), txb[k], k, 1'b0);

        // R5: one tick short of the reload does not realign
        ticks(RL - 1);
        send_byte(8'h3C, txb[3], 3, 1'b0);

        // R6: partial byte discarded by timeout
        send_bits(8'hF0, 4, 8'h00, 1'b0);
        ticks(RL);
        send_byte(8'hA5, txb[0], 0, 1'b0);

        // R7: extra ticks after expiry leave the idle state alone
        ticks(RL);
        ticks(5);
        wr(0, 8'h5A);
        repeat (4) @(negedge clk);
        chk("R7 still idle after extra ticks", 32'(sdo), 32'd0);
        send_byte(8'h81, txb[0], 0, 1'b0);
        send_byte(8'h7E, txb[1], 1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule